// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of instructions in a speculative out-of-order core, from the moment they issue until they retire. Each accepted issue takes the entry at the tail of a circular buffer, and the index of that entry comes back at once as the tag. Execution units later broadcast their results on a shared result bus under that tag. Until it retires, an entry holds its kind, its destination and its value. Operand lookups can read a finished value straight out of the buffer.

Retirement takes place only at the head, one entry per cycle at most, and only once the head entry is complete. A register operation writes the register file. A store writes memory, so memory never sees a store that was issued under a wrong guess. A correctly predicted branch just leaves the buffer. A branch that turns out to be mispredicted empties the whole buffer, but only when it has reached the head. In the same cycle the block signals a restart at the correct successor address, which is taken from the branch's result value.

Top module: `reorder_window`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `issueTag` is 0, `rfWe`, `memWe` and `redirectValid` are 0, and every lookup misses.
- R2: An accepted issue (`issueValid` and `issueReady` both high at a clock edge) takes the entry named by `issueTag`. The tag then steps by one, modulo DEPTH, so tags are handed out in issue order and wrap around.
- R3: The `issueKind` codes are: 2'b00 register operation, 2'b01 store, 2'b10 branch, and 2'b11 handled exactly like a register operation. For a register operation the destination register number is the low REG_W bits of `issueDest`. For a store the full `issueDest` is the memory address.
- R4: The head entry retires only when it is complete. Retiring a register operation raises `rfWe` with `rfAddr`/`rfData`. Retiring a store raises `memWe` with `memAddr`/`memData`. These outputs are high during the cycle in which the head is complete, and the entry leaves at the following edge. At most one of `rfWe`, `memWe` and `redirectValid` is high in any cycle.
- R5: While DEPTH entries are held, `issueReady` is 0, and an `issueValid` in that state adds no entry.
- R6: A `resValid` whose `resTag` names a held, unfinished entry stores `resValue` and `resMispredict` in that entry and marks it complete. A result for an entry that is already complete or not held is ignored.
- R7: A lookup hits only when its tag names a held, complete entry, and it then returns that entry's value. Otherwise it misses.
- R8: When the complete head is a branch with its mispredict flag set, `redirectValid` is 1 for that cycle and `redirectPc` equals the branch's result value. No register or memory write happens in that cycle. `issueReady` is 0 in that cycle, so an issue offered then is dropped. After the edge the buffer is empty and `issueTag` is 0.
- R9: A complete branch at the head with its mispredict flag clear retires with `rfWe`, `memWe` and `redirectValid` all 0.
- R10: An entry that completes before older entries do waits and retires only after all of them, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is offered for issue |
| issueKind | input | 2 | Instruction kind code (R3) |
| issueDest | input | XLEN | Register number (low bits) or store address |
| issueValue | input | XLEN | Value known at issue (result or store data) |
| issueDone | input | 1 | The value is already known, so the entry starts complete |
| issueReady | output | 1 | The buffer can take an issue this cycle |
| issueTag | output | log2(DEPTH) | Tag the next accepted issue receives |
| resValid | input | 1 | Result bus carries a result |
| resTag | input | log2(DEPTH) | Entry the result belongs to |
| resValue | input | XLEN | Result value or branch successor address |
| resMispredict | input | 1 | Branch result: the prediction was wrong |
| lookupTag | input | LOOKUPS*log2(DEPTH) | Lookup tags, port 0 in the low bits |
| lookupHit | output | LOOKUPS | Lookup found a complete entry |
| lookupValue | output | LOOKUPS*XLEN | Value for each lookup port |
| rfWe | output | 1 | Register file write at retirement |
| rfAddr | output | REG_W | Register number written |
| rfData | output | XLEN | Register value written |
| memWe | output | 1 | Memory write at store retirement |
| memAddr | output | XLEN | Store address |
| memData | output | XLEN | Store data |
| redirectValid | output | 1 | Mispredicted branch retired, buffer flushed |
| redirectPc | output | XLEN | Correct successor address |

## Verification
The bench builds the buffer with DEPTH 4, XLEN 16, REG_W 5 and two lookup ports. A depth of four lets a few issues fill the buffer and wrap the tag counter, so the full-stall and wrap-around cases are reached in a handful of cycles. Two lookup ports let the bench look at a complete entry and an unfinished one in the same cycle. A 16-bit width is still wide enough for store addresses and redirect targets that differ from register numbers.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } entryKind_e;

  // strobes from the control to the entry storage
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic                       headDone,
  input  entryKind_e                 headKind,
  input  logic                       headMisp,
  output robStrobe_t                 strobe,
  output logic [$clog2(DEPTH)-1:0]   headIdx,
  output logic [$clog2(DEPTH)-1:0]   tailIdx,
  output logic                       issueReady
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr;
  logic isEmpty, isFull, headGo, doFlush;

  assign isEmpty = (headPtr == tailPtr);
  assign isFull  = (headPtr[IDX_W] != tailPtr[IDX_W]) &&
                   (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]);

  assign headGo  = !isEmpty && headDone;
  assign doFlush = headGo && (headKind == KIND_BRANCH) && headMisp;

  assign issueReady    = !isFull && !doFlush;
  assign strobe.alloc  = issueValid && issueReady;
  assign strobe.retire = headGo && !doFlush;
  assign strobe.flush  = doFlush;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobe.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.alloc)  tailPtr <= tailPtr + 1'b1;
      if (strobe.retire) headPtr <= headPtr + 1'b1;
    end
  end

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int XLEN    = 32,
  parameter int LOOKUPS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  robStrobe_t                        strobe,
  input  logic [$clog2(DEPTH)-1:0]          headIdx,
  input  logic [$clog2(DEPTH)-1:0]          tailIdx,
  input  logic [1:0]                        issueKind,
  input  logic [XLEN-1:0]                   issueDest,
  input  logic [XLEN-1:0]                   issueValue,
  input  logic                              issueDone,
  input  logic                              resValid,
  input  logic [$clog2(DEPTH)-1:0]          resTag,
  input  logic [XLEN-1:0]                   resValue,
  input  logic                              resMispredict,
  input  logic [LOOKUPS*$clog2(DEPTH)-1:0]  lookupTag,
  output logic                              headDone,
  output entryKind_e                        headKind,
  output logic                              headMisp,
  output logic [XLEN-1:0]                   headDest,
  output logic [XLEN-1:0]                   headValue,
  output logic [LOOKUPS-1:0]                lookupHit,
  output logic [LOOKUPS*XLEN-1:0]           lookupValue
);

  localparam int IDX_W = $clog2(DEPTH);

  logic            validQ [DEPTH];
  logic            doneQ  [DEPTH];
  logic            mispQ  [DEPTH];
  entryKind_e      kindQ  [DEPTH];
  logic [XLEN-1:0] destQ  [DEPTH];
  logic [XLEN-1:0] valueQ [DEPTH];

  entryKind_e issueKindN;
  assign issueKindN = (issueKind == 2'b11) ? KIND_REG : entryKind_e'(issueKind);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        validQ[i] <= 1'b0;
        doneQ[i]  <= 1'b0;
        mispQ[i]  <= 1'b0;
        kindQ[i]  <= KIND_REG;
        destQ[i]  <= '0;
        valueQ[i] <= '0;
      end
    end else if (strobe.flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        validQ[i] <= 1'b0;
        doneQ[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.retire && headIdx == IDX_W'(i)) validQ[i] <= 1'b0;
        if (strobe.alloc && tailIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          kindQ[i]  <= issueKindN;
          destQ[i]  <= issueDest;
          valueQ[i] <= issueValue;
          doneQ[i]  <= issueDone;
          mispQ[i]  <= 1'b0;
        end else if (resValid && resTag == IDX_W'(i) && validQ[i] && !doneQ[i]) begin
          valueQ[i] <= resValue;
          doneQ[i]  <= 1'b1;
          mispQ[i]  <= resMispredict;
        end
      end
    end
  end

  assign headDone  = validQ[headIdx] && doneQ[headIdx];
  assign headKind  = kindQ[headIdx];
  assign headMisp  = mispQ[headIdx];
  assign headDest  = destQ[headIdx];
  assign headValue = valueQ[headIdx];

  for (genvar p = 0; p < LOOKUPS; p++) begin : gLookup
    logic [IDX_W-1:0] portTag;
    assign portTag = lookupTag[p*IDX_W +: IDX_W];
    assign lookupHit[p] = validQ[portTag] && doneQ[portTag];
    assign lookupValue[p*XLEN +: XLEN] = valueQ[portTag];
  end

endmodule

// File: rtl/reorder_window.sv
module reorder_window
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int LOOKUPS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              issueValid,
  input  logic [1:0]                        issueKind,
  input  logic [XLEN-1:0]                   issueDest,
  input  logic [XLEN-1:0]                   issueValue,
  input  logic                              issueDone,
  output logic                              issueReady,
  output logic [$clog2(DEPTH)-1:0]          issueTag,
  input  logic                              resValid,
  input  logic [$clog2(DEPTH)-1:0]          resTag,
  input  logic [XLEN-1:0]                   resValue,
  input  logic                              resMispredict,
  input  logic [LOOKUPS*$clog2(DEPTH)-1:0]  lookupTag,
  output logic [LOOKUPS-1:0]                lookupHit,
  output logic [LOOKUPS*XLEN-1:0]           lookupValue,
  output logic                              rfWe,
  output logic [REG_W-1:0]                  rfAddr,
  output logic [XLEN-1:0]                   rfData,
  output logic                              memWe,
  output logic [XLEN-1:0]                   memAddr,
  output logic [XLEN-1:0]                   memData,
  output logic                              redirectValid,
  output logic [XLEN-1:0]                   redirectPc
);

  localparam int IDX_W = $clog2(DEPTH);

  robStrobe_t       ctrlStrobe;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             headDone, headMisp;
  entryKind_e       headKind;
  logic [XLEN-1:0]  headDest, headValue;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .headDone   (headDone),
    .headKind   (headKind),
    .headMisp   (headMisp),
    .strobe     (ctrlStrobe),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .issueReady (issueReady)
  );

  rob_data #(.DEPTH(DEPTH), .XLEN(XLEN), .LOOKUPS(LOOKUPS)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (ctrlStrobe),
    .headIdx       (headIdx),
    .tailIdx       (tailIdx),
    .issueKind     (issueKind),
    .issueDest     (issueDest),
    .issueValue    (issueValue),
    .issueDone     (issueDone),
    .resValid      (resValid),
    .resTag        (resTag),
    .resValue      (resValue),
    .resMispredict (resMispredict),
    .lookupTag     (lookupTag),
    .headDone      (headDone),
    .headKind      (headKind),
    .headMisp      (headMisp),
    .headDest      (headDest),
    .headValue     (headValue),
    .lookupHit     (lookupHit),
    .lookupValue   (lookupValue)
  );

  assign issueTag      = tailIdx;
  assign rfWe          = ctrlStrobe.retire && (headKind == KIND_REG);
  assign rfAddr        = headDest[REG_W-1:0];
  assign rfData        = headValue;
  assign memWe         = ctrlStrobe.retire && (headKind == KIND_STORE);
  assign memAddr       = headDest;
  assign memData       = headValue;
  assign redirectValid = ctrlStrobe.flush;
  assign redirectPc    = headValue;

endmodule

// File: rtl/reorder_window_chk.sv
module reorder_window_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     issueValid,
  input logic                     issueReady,
  input logic [$clog2(DEPTH)-1:0] issueTag,
  input logic                     retireStrobe,
  input logic                     rfWe,
  input logic                     memWe,
  input logic                     redirectValid
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  // independent occupancy count, kept from the handshakes alone
  logic [PTR_W-1:0] occ;
  logic             accepted;
  assign accepted = issueValid && issueReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              occ <= '0;
    else if (redirectValid) occ <= '0;
    else                    occ <= occ + PTR_W'(accepted) - PTR_W'(retireStrobe);
  end

  // R4: one retirement action per cycle
  a_r4_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rfWe, memWe, redirectValid}));

  // R2: tag steps by one after each accepted issue
  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (issueTag == IDX_W'($past(issueTag) + 1'b1)));

  // R5: no issue accepted when full
  a_r5_full_stall: assert property (@(posedge clk) disable iff (!rstN)
    (occ == PTR_W'(DEPTH)) |-> !issueReady);

  // R5: ready whenever there is room and no flush
  a_r5_room_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((occ != PTR_W'(DEPTH)) && !redirectValid) |-> issueReady);

  // R4: nothing retires from an empty buffer
  a_r4_retire_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe || memWe || redirectValid || retireStrobe) |-> (occ != '0));

  // R8: a flush leaves an empty buffer with tag zero
  a_r8_flush_restart: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (issueTag == '0 && !rfWe && !memWe && !redirectValid));

endmodule

bind reorder_window reorder_window_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .issueValid    (issueValid),
  .issueReady    (issueReady),
  .issueTag      (issueTag),
  .retireStrobe  (ctrlStrobe.retire),
  .rfWe          (rfWe),
  .memWe         (memWe),
  .redirectValid (redirectValid)
);

// File: tb/reorder_window_bench.sv
`timescale 1ns/1ps
module reorder_window_bench;

  localparam int DEPTH = 4;
  localparam int XLEN  = 16;
  localparam int REG_W = 5;
  localparam int LOOKUPS = 2;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueKind = 2'b00;
  logic [XLEN-1:0] issueDest = '0, issueValue = '0;
  logic issueDone = 1'b0;
  logic issueReady;
  logic [IDX_W-1:0] issueTag;
  logic resValid = 1'b0;
  logic [IDX_W-1:0] resTag = '0;
  logic [XLEN-1:0] resValue = '0;
  logic resMispredict = 1'b0;
  logic [IDX_W-1:0] lkA = '0, lkB = '0;
  logic [LOOKUPS*IDX_W-1:0] lookupTag;
  logic [LOOKUPS-1:0] lookupHit;
  logic [LOOKUPS*XLEN-1:0] lookupValue;
  logic rfWe, memWe, redirectValid;
  logic [REG_W-1:0] rfAddr;
  logic [XLEN-1:0] rfData, memAddr, memData, redirectPc;

  assign lookupTag = {lkB, lkA};

  always #2.5 clk = ~clk;

  reorder_window #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W), .LOOKUPS(LOOKUPS)) u_reorder_window (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueKind(issueKind), .issueDest(issueDest),
    .issueValue(issueValue), .issueDone(issueDone),
    .issueReady(issueReady), .issueTag(issueTag),
    .resValid(resValid), .resTag(resTag), .resValue(resValue), .resMispredict(resMispredict),
    .lookupTag(lookupTag), .lookupHit(lookupHit), .lookupValue(lookupValue),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  typedef struct packed {
    logic [1:0]      kind;
    logic [XLEN-1:0] dest;
    logic [XLEN-1:0] value;
    logic            viaBus;
    logic            expRf;
    logic            expMem;
  } vec_t;

  // kind codes: 00 reg, 01 store, 10 branch, 11 reg
  localparam vec_t VECS [6] = '{
    '{2'b00, 16'h0003, 16'h1234, 1'b0, 1'b1, 1'b0},
    '{2'b00, 16'h001F, 16'hABCD, 1'b1, 1'b1, 1'b0},
    '{2'b01, 16'h8000, 16'h5555, 1'b0, 1'b0, 1'b1},
    '{2'b01, 16'h0FF0, 16'h1111, 1'b1, 1'b0, 1'b1},
    '{2'b10, 16'h0000, 16'h0040, 1'b1, 1'b0, 1'b0},
    '{2'b11, 16'h0007, 16'h7777, 1'b0, 1'b1, 1'b0}
  };

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [IDX_W-1:0] expTag = '0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [XLEN-1:0] d,
                       input logic [XLEN-1:0] val, input logic dn);
    issueValid = 1'b1; issueKind = k; issueDest = d; issueValue = val; issueDone = dn;
    tick();
    issueValid = 1'b0;
    expTag = expTag + 1'b1;
  endtask

  task automatic result(input logic [IDX_W-1:0] t, input logic [XLEN-1:0] val, input logic mp);
    resValid = 1'b1; resTag = t; resValue = val; resMispredict = mp;
    tick();
    resValid = 1'b0; resMispredict = 1'b0;
  endtask

  task automatic quiet(input string req);
    check(req, "rfWe", rfWe, 0);
    check(req, "memWe", memWe, 0);
    check(req, "redirectValid", redirectValid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1", "issueReady", issueReady, 1);
    check("R1", "issueTag", issueTag, 0);
    quiet("R1");
    check("R1", "lookupHit", lookupHit, 0);

    // vector table walk: one instruction at a time
    for (int v = 0; v < 6; v++) begin
      string rq;
      rq = (v == 4) ? "R9" : (v == 5) ? "R3" : "R4";
      check("R2", "issueTag", issueTag, expTag);
      issue(VECS[v].kind, VECS[v].dest, VECS[v].value, !VECS[v].viaBus);
      if (VECS[v].viaBus) begin
        quiet("R4");
        result(expTag - 1'b1, VECS[v].value, 1'b0);
      end
      check(rq, "rfWe", rfWe, VECS[v].expRf);
      check(rq, "memWe", memWe, VECS[v].expMem);
      check(rq, "redirectValid", redirectValid, 0);
      if (VECS[v].expRf) begin
        check("R3", "rfAddr", rfAddr, VECS[v].dest[REG_W-1:0]);
        check(rq, "rfData", rfData, VECS[v].value);
      end
      if (VECS[v].expMem) begin
        check("R3", "memAddr", memAddr, VECS[v].dest);
        check(rq, "memData", memData, VECS[v].value);
      end
      tick();
    end
    quiet("R4");
    check("R2", "wrapped issueTag", issueTag, 2);

    // R10 / R7 / R6: out-of-order completion, tags 2, 3, 0
    issue(2'b00, 16'h0001, 16'h0000, 1'b0);
    issue(2'b00, 16'h0002, 16'h0000, 1'b0);
    issue(2'b01, 16'h0100, 16'h0022, 1'b1);
    quiet("R10");
    lkA = 2'd0; lkB = 2'd3; #1;
    check("R7", "hit complete store", lookupHit[0], 1);
    check("R7", "value complete store", lookupValue[XLEN-1:0], 16'h0022);
    check("R7", "miss unfinished", lookupHit[1], 0);
    result(2'd3, 16'h0033, 1'b0);
    quiet("R10");
    check("R7", "hit after result", lookupHit[1], 1);
    check("R6", "captured value", lookupValue[2*XLEN-1:XLEN], 16'h0033);
    result(2'd3, 16'h0099, 1'b0);
    check("R6", "second result ignored", lookupValue[2*XLEN-1:XLEN], 16'h0033);
    result(2'd2, 16'h0044, 1'b0);
    check("R10", "oldest first rfWe", rfWe, 1);
    check("R10", "oldest first rfAddr", rfAddr, 1);
    check("R10", "oldest first rfData", rfData, 16'h0044);
    tick();
    check("R10", "second rfAddr", rfAddr, 2);
    check("R10", "second rfData", rfData, 16'h0033);
    tick();
    check("R10", "store memWe", memWe, 1);
    check("R10", "store memAddr", memAddr, 16'h0100);
    tick();
    quiet("R10");

    // R5: fill with four unfinished entries, tags 1, 2, 3, 0
    for (int k = 0; k < 4; k++) begin
      check("R5", "ready before fill", issueReady, 1);
      issue(2'b00, XLEN'(k + 10), 16'h0000, 1'b0);
    end
    check("R5", "ready when full", issueReady, 0);
    issueValid = 1'b1; issueKind = 2'b00; issueDest = 16'h001E; issueValue = 16'hDEAD; issueDone = 1'b1;
    tick();
    issueValid = 1'b0;
    expTag = 2'd1;
    quiet("R5");
    for (int k = 0; k < 4; k++) begin
      result(IDX_W'(k + 1), XLEN'(16'h0100 + k), 1'b0);
      check("R5", "drain rfWe", rfWe, 1);
      check("R5", "drain rfData", rfData, 16'h0100 + k);
    end
    tick();
    check("R5", "no extra entry rfWe", rfWe, 0);

    // R8: mispredicted branch at head with younger entries, tags 1, 2, 3
    issue(2'b10, 16'h0000, 16'h0000, 1'b0);
    issue(2'b00, 16'h0005, 16'h0055, 1'b1);
    issue(2'b01, 16'h0200, 16'h0066, 1'b1);
    quiet("R8");
    lkA = 2'd2; #1;
    check("R7", "younger value visible", lookupHit[0], 1);
    result(2'd1, 16'h0200, 1'b1);
    check("R8", "redirectValid", redirectValid, 1);
    check("R8", "redirectPc", redirectPc, 16'h0200);
    check("R8", "no rfWe", rfWe, 0);
    check("R8", "no memWe", memWe, 0);
    check("R8", "issueReady low", issueReady, 0);
    issueValid = 1'b1; issueKind = 2'b00; issueDest = 16'h0003; issueValue = 16'hBEEF; issueDone = 1'b1;
    tick();
    issueValid = 1'b0;
    expTag = 2'd0;
    check("R8", "tag after flush", issueTag, 0);
    quiet("R8");
    lkA = 2'd2; lkB = 2'd0; #1;
    check("R8", "younger entry gone", lookupHit[0], 0);
    check("R8", "dropped issue absent", lookupHit[1], 0);

    // restart after flush
    issue(2'b00, 16'h0009, 16'h0099, 1'b1);
    check("R8", "restart rfWe", rfWe, 1);
    check("R8", "restart rfAddr", rfAddr, 9);
    tick();

    // R6: result for a free entry is ignored, tag 1 is free now
    result(2'd1, 16'h0077, 1'b0);
    quiet("R6");
    issue(2'b00, 16'h000C, 16'h0000, 1'b0);
    check("R6", "no stale completion", rfWe, 0);
    lkA = 2'd1; #1;
    check("R6", "lookup of new entry misses", lookupHit[0], 0);
    result(2'd1, 16'h0078, 1'b0);
    check("R6", "late rfWe", rfWe, 1);
    check("R6", "late rfData", rfData, 16'h0078);
    tick();
    quiet("R4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule